// File: doc/BRIEF.md
# Dual-Slope Buffered PWM Timer

This block produces symmetric, center-aligned pulse-width modulation for motor-drive outputs. A counter climbs one step per enabled timer tick from zero to a programmable ceiling (TOP). It stays at the ceiling for a single tick and then descends back to zero. The cycle then repeats, so one period spans `2*TOP` ticks. The ceiling comes from a dedicated period register or from the compare register of channel 0, as a select input chooses.

Each compare channel owns one output pin. The pin falls when the count meets the channel's compare value on the rising slope and rises on a match on the falling slope. An inverting mode swaps the two levels, and a disabled mode holds the pin low. Software writes period and compare values into shadow buffers at any time. The live copies take the buffer contents only when the counter sits at zero, so each period keeps its own symmetry and a change of period cannot glitch. The block raises status flags at the bottom, at the ceiling and on every compare match. Writing 1 to a flag bit clears it.

Top module: `dual_slope_pwm`

## Requirements
- R1: After reset the count is 0. On enabled ticks it steps 0,1,…,TOP,TOP-1,…,1,0 and repeats. Each value lasts one tick, TOP is held for exactly one tick, and a period is 2*TOP ticks.
- R2: On a cycle with `tick` low, the count, the outputs and the counting direction do not change.
- R3: With `top_sel`=0 the ceiling is the period buffer (write address 0). With `top_sel`=1 it is channel 0's compare buffer (write address 1). Channel i's compare buffer is at write address i+1.
- R4: Writes land in the buffers at any time. The live ceiling, compare values and `top_sel` choice are loaded from them on a tick where the count is 0. The count never exceeds the live ceiling.
- R5: Mode code 2 (`out_mode[2i+1:2i]`) is non-inverting. A match on the rising slope (including the ceiling tick and the zero tick) drives the pin low, and a match on the falling slope drives it high. In steady state with compare C, the pin is high for 2*C ticks per period when C<TOP and for 0 ticks when C=TOP.
- R6: Mode code 3 is inverting. The pin is the complement of what code 2 would give, which is 2*TOP−2*C high ticks for C<TOP and 2*TOP for C=TOP. The internal level resets to low, so an inverting pin starts high.
- R7: Mode codes 0 and 1 hold the pin low.
- R8: `flags[0]` sets on each tick where the count is 0. On the ceiling tick, `flags[1]` sets when the live selection is the period buffer, and `flags[2]` sets when it is channel 0.
- R9: `flags[2+i]` sets on each tick where the count equals channel i's live compare value.
- R10: A 1 on `flag_clr[k]` clears flag k at the next edge. If the flag is being set on that same edge, it stays set.
- R11: A ceiling value below 3 is loaded as 3, so the smallest period is 6 ticks. The full counter range is allowed as the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable, one count step per high cycle |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(N_CH+1) | 0 = period buffer, i+1 = compare buffer of channel i |
| wr_data | input | CNT_W | Value written into the addressed buffer |
| top_sel | input | 1 | Ceiling source: 0 period buffer, 1 channel 0 compare |
| out_mode | input | 2*N_CH | Two-bit output mode per channel: 0/1 off, 2 non-inverting, 3 inverting |
| flag_clr | input | N_CH+2 | Write-1-to-clear strobes for the flags |
| pwm_out | output | N_CH | PWM pins, one per channel |
| cnt_out | output | CNT_W | Current count value |
| flags | output | N_CH+2 | Bit 0 bottom, bit 1 period ceiling, bit 2+i channel i match |

## Verification
The bench builds the timer with an 8-bit counter and two channels. This keeps every period down to a few dozen cycles. It can therefore sweep every ceiling from 3 to 9 against every compare value from 0 to the ceiling, with one channel non-inverting and the other inverting on the mirrored value, and it compares high-tick counts and the triangle shape with closed-form expectations. The short periods also make it cheap to probe the cases at the edges: a ceiling written mid-period, a ceiling below the floor, channel 0 acting as ceiling, and a clear colliding with a set on the same edge.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
   localparam int FL_BOT  = 0;
   localparam int FL_PER  = 1;
   localparam int FL_CMP0 = 2;

   localparam int MODE_EN_BIT  = 1;
   localparam int MODE_INV_BIT = 0;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;
endpackage

// File: rtl/dspwm_regs.sv
module dspwm_regs #(
   parameter int CNT_W   = 16,
   parameter int N_CH    = 3,
   parameter int AW      = 2,
   parameter int TOP_MIN = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [AW-1:0]                  wr_addr,
   input  logic [CNT_W-1:0]               wr_data,
   input  logic                           top_sel,
   input  logic                           load,
   output logic [CNT_W-1:0]               top_act,
   output logic [N_CH-1:0][CNT_W-1:0]     cmp_act,
   output logic                           sel_act
);
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(TOP_MIN);

   logic [CNT_W-1:0]           per_buf;
   logic [N_CH-1:0][CNT_W-1:0] cmp_buf;
   logic [CNT_W-1:0]           top_src;
   logic [CNT_W-1:0]           top_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_buf <= '1;
         cmp_buf <= '0;
      end else if (wr_en) begin
         if (wr_addr == '0) per_buf <= wr_data;
         for (int i = 0; i < N_CH; i++) begin
            if (wr_addr == AW'(i + 1)) cmp_buf[i] <= wr_data;
         end
      end
   end

   assign top_src = top_sel ? cmp_buf[0] : per_buf;
   assign top_lim = (top_src < FLOOR) ? FLOOR : top_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_act <= '1;
         cmp_act <= '0;
         sel_act <= 1'b0;
      end else if (load) begin
         top_act <= top_lim;
         cmp_act <= cmp_buf;
         sel_act <= top_sel;
      end
   end
endmodule

// File: rtl/dspwm_counter.sv
module dspwm_counter
   import dspwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up,
   output logic             bottom_ev,
   output logic             top_ev
);
   dir_e dir;

   assign dir_up    = (dir == DIR_UP);
   assign bottom_ev = tick && (cnt == '0);
   assign top_ev    = tick && dir_up && (cnt >= top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         dir <= DIR_UP;
      end else if (tick) begin
         if (dir_up) begin
            if (cnt >= top) begin
               cnt <= cnt - 1'b1;
               dir <= DIR_DOWN;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) dir <= DIR_UP;
         end
      end
   end
endmodule

// File: rtl/dspwm_chan.sv
module dspwm_chan
   import dspwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             dir_up,
   input  logic [1:0]       mode,
   output logic             pin,
   output logic             match
);
   logic wav;

   assign match = tick && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wav <= 1'b0;
      else if (match) wav <= ~dir_up;
   end

   assign pin = mode[MODE_EN_BIT] & (wav ^ mode[MODE_INV_BIT]);
endmodule

// File: rtl/dspwm_flags.sv
module dspwm_flags #(
   parameter int N_FL = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_FL-1:0] set,
   input  logic [N_FL-1:0] clr,
   output logic [N_FL-1:0] flags
);
   for (genvar k = 0; k < N_FL; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[k] <= 1'b0;
         else        flags[k] <= (flags[k] & ~clr[k]) | set[k];
      end
   end
endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm
   import dspwm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_CH  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          wr_en,
   input  logic [$clog2(N_CH+1)-1:0]     wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   input  logic                          top_sel,
   input  logic [2*N_CH-1:0]             out_mode,
   input  logic [N_CH+1:0]               flag_clr,
   output logic [N_CH-1:0]               pwm_out,
   output logic [CNT_W-1:0]              cnt_out,
   output logic [N_CH+1:0]               flags
);
   localparam int AW      = $clog2(N_CH + 1);
   localparam int N_FL    = N_CH + 2;
   localparam int TOP_MIN = 3;

   if (CNT_W < 2 || N_CH < 1) begin : g_bad_cfg
      $error("dual_slope_pwm: CNT_W must be >= 2 and N_CH >= 1");
   end

   logic [CNT_W-1:0]           top_act;
   logic [N_CH-1:0][CNT_W-1:0] cmp_act;
   logic                       sel_act;
   logic                       dir_up;
   logic                       bottom_ev;
   logic                       top_ev;
   logic [N_CH-1:0]            match;
   logic [N_FL-1:0]            flag_set;

   dspwm_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .AW(AW), .TOP_MIN(TOP_MIN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .top_sel (top_sel),
      .load    (bottom_ev),
      .top_act (top_act),
      .cmp_act (cmp_act),
      .sel_act (sel_act)
   );

   dspwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .top       (top_act),
      .cnt       (cnt_out),
      .dir_up    (dir_up),
      .bottom_ev (bottom_ev),
      .top_ev    (top_ev)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      dspwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .cnt    (cnt_out),
         .cmp    (cmp_act[i]),
         .dir_up (dir_up),
         .mode   (out_mode[2*i +: 2]),
         .pin    (pwm_out[i]),
         .match  (match[i])
      );
   end

   always_comb begin
      flag_set          = '0;
      flag_set[FL_BOT]  = bottom_ev;
      flag_set[FL_PER]  = top_ev & ~sel_act;
      for (int i = 0; i < N_CH; i++) flag_set[FL_CMP0 + i] = match[i];
      flag_set[FL_CMP0] = flag_set[FL_CMP0] | (top_ev & sel_act);
   end

   dspwm_flags #(.N_FL(N_FL)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flags (flags)
   );
endmodule

// File: rtl/dspwm_chk.sv
module dspwm_chk #(
   parameter int CNT_W = 16,
   parameter int N_CH  = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick,
   input logic [CNT_W-1:0]     cnt,
   input logic [CNT_W-1:0]     top_act,
   input logic [2*N_CH-1:0]    out_mode,
   input logic [N_CH-1:0]      pwm_out,
   input logic [N_CH+1:0]      flags,
   input logic [N_CH+1:0]      flag_clr
);
   // R1
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (CNT_W'(cnt - $past(cnt)) == CNT_W'(1)) ||
               (CNT_W'(cnt - $past(cnt)) == {CNT_W{1'b1}}));

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt) && $stable(pwm_out));

   // R4
   cnt_le_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= top_act);

   // R11
   top_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      top_act >= CNT_W'(3));

   // R8
   bottom_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == '0) |=> flags[0]);

   // R10
   clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[0] && !(tick && cnt == '0)) |=> !flags[0]);

   for (genvar i = 0; i < N_CH; i++) begin : g_off
      // R7
      off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !out_mode[2*i+1] |-> !pwm_out[i]);
   end
endmodule

bind dual_slope_pwm dspwm_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .cnt      (cnt_out),
   .top_act  (top_act),
   .out_mode (out_mode),
   .pwm_out  (pwm_out),
   .flags    (flags),
   .flag_clr (flag_clr)
);

// File: tb/tb_dual_slope_pwm.sv
module tb_dual_slope_pwm;
   localparam int CW = 8;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          top_sel = 1'b0;
   logic [3:0]    out_mode = 4'b1110;
   logic [3:0]    flag_clr = '0;
   logic [1:0]    pwm_out;
   logic [CW-1:0] cnt_out;
   logic [3:0]    flags;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dual_slope_pwm #(.CNT_W(CW), .N_CH(NC)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .top_sel(top_sel), .out_mode(out_mode),
      .flag_clr(flag_clr), .pwm_out(pwm_out), .cnt_out(cnt_out), .flags(flags)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_bottom();
      forever begin
         @(negedge clk);
         if (cnt_out == '0) break;
      end
   endtask

   // measure from a bottom over one period: shape errors and high counts
   task automatic measure(input int t, output int shape_err, output int h0, output int h1);
      shape_err = 0; h0 = 0; h1 = 0;
      for (int k = 0; k < 2*t; k++) begin
         if (k > 0) @(negedge clk);
         if (int'(cnt_out) != ((k <= t) ? k : 2*t - k)) shape_err++;
         h0 += int'(pwm_out[0]);
         h1 += int'(pwm_out[1]);
      end
   endtask

   task automatic period_len(output int len, output int mx);
      wait_bottom();
      len = 0; mx = 0;
      do begin
         @(negedge clk);
         len++;
         if (int'(cnt_out) > mx) mx = int'(cnt_out);
      end while (cnt_out != '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int se, h0, h1, e0, e1, c1, len, mx, c;
      logic [1:0] p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cnt_out == '0, "R1 reset count", int'(cnt_out), 0);
      chk(flags == '0, "R8 reset flags", int'(flags), 0);
      // R6 inverting pin starts high from the low internal level
      chk(pwm_out == 2'b10, "R6 reset pins", int'(pwm_out), 2);

      // R5 R6 R1 exhaustive sweep
      for (int t = 3; t <= 9; t++) begin
         for (int cv = 0; cv <= t; cv++) begin
            wr(0, t); wr(1, cv); wr(2, t - cv);
            tick = 1'b1;
            repeat (3) wait_bottom();
            measure(t, se, h0, h1);
            c1 = t - cv;
            e0 = (cv < t) ? 2*cv : 0;
            e1 = 2*t - ((c1 < t) ? 2*c1 : 0);
            chk(se == 0, "R1 triangle shape", se, 0);
            chk(h0 == e0, "R5 non-inverting high ticks", h0, e0);
            chk(h1 == e1, "R6 inverting high ticks", h1, e1);
         end
      end

      // R2 tick gating
      @(negedge clk);
      tick = 1'b0;
      c = int'(cnt_out); p = pwm_out;
      repeat (6) @(negedge clk);
      chk(int'(cnt_out) == c, "R2 count holds without tick", int'(cnt_out), c);
      chk(pwm_out == p, "R2 pins hold without tick", int'(pwm_out), int'(p));
      tick = 1'b1;
      @(negedge clk);
      chk(int'(cnt_out) != c, "R2 count resumes", int'(cnt_out), c + 1);

      // R4 buffered ceiling change mid-period
      wr(0, 9);
      repeat (2) wait_bottom();
      @(negedge clk); @(negedge clk);
      wr(0, 4);
      mx = 0;
      do begin
         @(negedge clk);
         if (int'(cnt_out) > mx) mx = int'(cnt_out);
      end while (cnt_out != '0);
      chk(mx == 9, "R4 current period keeps old ceiling", mx, 9);
      len = 0; mx = 0;
      do begin
         @(negedge clk);
         len++;
         if (int'(cnt_out) > mx) mx = int'(cnt_out);
      end while (cnt_out != '0);
      chk(mx == 4, "R4 new ceiling after bottom", mx, 4);
      chk(len == 8, "R4 new period length", len, 8);

      // R11 floor on ceiling
      wr(0, 1);
      wait_bottom();
      period_len(len, mx);
      chk(len == 6, "R11 clamped period", len, 6);
      chk(mx == 3, "R11 clamped ceiling", mx, 3);

      // R3 channel 0 as ceiling source
      top_sel = 1'b1;
      wr(1, 6); wr(0, 200);
      repeat (2) wait_bottom();
      period_len(len, mx);
      chk(len == 12, "R3 period from channel 0", len, 12);
      chk(mx == 6, "R3 ceiling from channel 0", mx, 6);
      // cnt is 0 now: clear all; next full period
      flag_clr = 4'b1111;
      @(negedge clk);
      flag_clr = 4'b0000;
      wait_bottom();
      chk(flags[1] == 1'b0, "R8 period flag idle with channel 0 ceiling", int'(flags[1]), 0);
      chk(flags[2] == 1'b1, "R8 channel 0 flag at ceiling", int'(flags[2]), 1);

      // R7 disabled modes
      top_sel = 1'b0;
      out_mode = 4'b0100;
      wr(0, 5); wr(1, 2); wr(2, 2);
      repeat (3) wait_bottom();
      measure(5, se, h0, h1);
      chk(h0 == 0, "R7 mode 0 holds low", h0, 0);
      chk(h1 == 0, "R7 mode 1 holds low", h1, 0);

      // R8 R9 R10 flags
      out_mode = 4'b1010;
      wr(2, 4);
      repeat (2) wait_bottom();
      wait_bottom();
      flag_clr = 4'b0001;
      @(negedge clk);
      flag_clr = 4'b0000;
      chk(flags[0] == 1'b1, "R10 set wins over clear", int'(flags[0]), 1);
      flag_clr = 4'b1111;
      @(negedge clk);
      flag_clr = 4'b0000;
      chk(flags == 4'b0000, "R10 write-1 clears", int'(flags), 0);
      do @(negedge clk); while (int'(cnt_out) != 5);
      @(negedge clk);
      chk(flags == 4'b1110, "R8 R9 ceiling and match flags", int'(flags), 14);
      flag_clr = 4'b1111;
      @(negedge clk);
      flag_clr = 4'b0000;
      chk(flags == 4'b1000, "R9 R10 falling match sets during clear", int'(flags), 8);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule